// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the register side of taking an exception in a small soft processor core. When the pipeline raises its taken strobe, the block looks at the 5-bit cause code and the status word that was current before the exception. In one clock edge it then writes the new status word, the saved copies of status and of the return address, the cause register, the TLB-miss flags and the program counter to fetch from next.

One bit of the incoming status word, the handler-active bit, steers most of the entry. It selects between the fast and the nested handling of a TLB miss. It decides whether fault-class exceptions keep the earlier return state. It also decides whether a break may overwrite its own save slot. Interrupts are gated by the previous-interrupt-enable bit. A cause code the block does not decode raises a one-cycle error pulse and changes nothing else. Instruction decode, the translation buffer itself and the return-from-exception path belong to neighbouring blocks.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted (active low) and after it is released, every registered output reads zero, including `entry_o` and `unhandled_o`.
- R2: The status bits sit at PIE = bit 0, U = bit 1, EH = bit 2 and IH = bit 3. Every accepted entry other than an interrupt writes `status_o` as `status_i` with EH set and PIE and U cleared. All outputs of an entry appear on the clock edge where `take_i` is high, and `entry_o` is high for the cycle that follows.
- R3: An accepted entry writes the cause code into bits [6:2] of `exc_reg_o`. Bits [1:0] and the bits above 6 stay 0.
- R4: Cause 2 is an interrupt. It is accepted only when status PIE is 1. It then copies status into `estatus_o`, writes status with IH set and PIE and U cleared (EH passed through unchanged), sets `ea_o` to PC+4 and loads the general vector. With PIE at 0, no output changes and `entry_o` stays low.
- R5: Cause 12 with EH at 0 is a fast TLB miss. It copies status into `estatus_o`, clears the double flag (`miss_flags_o` bit 1), sets the write flag (bit 0), sets `ea_o` to PC+4 and loads the fast-miss vector.
- R6: Cause 12 with EH at 1 is a nested miss. It sets the double flag, leaves the write flag, `estatus_o` and `ea_o` unchanged, and loads the general vector.
- R7: Causes 13, 14 and 15 (read, write and execute permission faults) copy status into `estatus_o` and PC+4 into `ea_o` whatever the value of EH. They leave the miss flags unchanged and load the general vector.
- R8: Causes 3 (trap), 5 (illegal) and 9, 10, 11 (supervisor-only) save status to `estatus_o` and PC+4 to `ea_o` only when EH was 0. They always load the general vector. PC+4 wraps modulo 2^AW.
- R9: Cause 7 (break) saves status to `bstatus_o` and PC+4 to `ba_o` only when EH was 0. It never changes `estatus_o` or `ea_o`.
- R10: Any other cause code pulses `unhandled_o` for one cycle after the take edge. No other output changes and `entry_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Exception taken strobe |
| cause_i | input | 5 | Cause code |
| pc_i | input | AW | PC of the excepting instruction |
| status_i | input | SW | Status word before the entry |
| gen_vec_i | input | AW | General exception vector |
| fast_miss_vec_i | input | AW | Fast TLB-miss vector |
| status_o | output | SW | Status word written by the entry |
| estatus_o | output | SW | Exception saved status |
| bstatus_o | output | SW | Break saved status |
| exc_reg_o | output | CW | Cause register |
| miss_flags_o | output | 2 | TLB-miss flags: bit 1 double, bit 0 write |
| ea_o | output | AW | Exception return address |
| ba_o | output | AW | Break return address |
| next_pc_o | output | AW | PC to fetch after the entry |
| entry_o | output | 1 | An entry was applied on the last edge |
| unhandled_o | output | 1 | Undecoded cause seen on the last edge |

## Verification
The bench builds the block with its default parameters: 32-bit PC, status and cause register, a 4-byte instruction step and translation support enabled. At these values the bench can sweep all 32 cause codes under every combination of the handler-active and interrupt-enable bits. This reaches every decoded class in both its fast and its nested form, and every undecoded code. A separate entry with the PC at the top of the address space checks that the return address wraps.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   typedef enum logic [2:0] {
      K_NONE, K_IRQ, K_MISS, K_PERM, K_FAULT, K_BREAK
   } exc_kind_e;

   localparam int unsigned ST_PIE = 0;
   localparam int unsigned ST_U   = 1;
   localparam int unsigned ST_EH  = 2;
   localparam int unsigned ST_IH  = 3;

   localparam int unsigned MF_WR  = 0;
   localparam int unsigned MF_DBL = 1;

   localparam int unsigned CAUSE_W   = 5;
   localparam int unsigned CAUSE_LSB = 2;

   localparam logic [CAUSE_W-1:0] CC_IRQ      = 5'd2;
   localparam logic [CAUSE_W-1:0] CC_TRAP     = 5'd3;
   localparam logic [CAUSE_W-1:0] CC_ILLEGAL  = 5'd5;
   localparam logic [CAUSE_W-1:0] CC_BREAK    = 5'd7;
   localparam logic [CAUSE_W-1:0] CC_SUP_ADDR = 5'd9;
   localparam logic [CAUSE_W-1:0] CC_SUP_INST = 5'd10;
   localparam logic [CAUSE_W-1:0] CC_SUP_DATA = 5'd11;
   localparam logic [CAUSE_W-1:0] CC_TLB_MISS = 5'd12;
   localparam logic [CAUSE_W-1:0] CC_TLB_RD   = 5'd13;
   localparam logic [CAUSE_W-1:0] CC_TLB_WR   = 5'd14;
   localparam logic [CAUSE_W-1:0] CC_TLB_EX   = 5'd15;
endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
   import exc_entry_pkg::*;
#(
   parameter bit HAS_MMU = 1'b1
) (
   input  logic [CAUSE_W-1:0] cause_i,
   output exc_kind_e          kind_o
);
   exc_kind_e core_kind;
   exc_kind_e tlb_kind;

   always_comb begin
      unique case (cause_i)
         CC_IRQ:                               core_kind = K_IRQ;
         CC_TRAP, CC_ILLEGAL,
         CC_SUP_ADDR, CC_SUP_INST, CC_SUP_DATA: core_kind = K_FAULT;
         CC_BREAK:                             core_kind = K_BREAK;
         default:                              core_kind = K_NONE;
      endcase
   end

   generate
      if (HAS_MMU) begin : g_mmu
         always_comb begin
            unique case (cause_i)
               CC_TLB_MISS:                    tlb_kind = K_MISS;
               CC_TLB_RD, CC_TLB_WR, CC_TLB_EX: tlb_kind = K_PERM;
               default:                        tlb_kind = K_NONE;
            endcase
         end
      end else begin : g_no_mmu
         assign tlb_kind = K_NONE;
      end
   endgenerate

   assign kind_o = (tlb_kind != K_NONE) ? tlb_kind : core_kind;
endmodule

// File: rtl/exc_save_policy.sv
module exc_save_policy
   import exc_entry_pkg::*;
(
   input  exc_kind_e kind_i,
   input  logic      eh_i,
   input  logic      pie_i,
   output logic      accept_o,
   output logic      save_e_o,
   output logic      save_b_o,
   output logic      fast_vec_o,
   output logic      irq_o,
   output logic      mf_fast_o,
   output logic      mf_dbl_o,
   output logic      bad_o
);
   always_comb begin
      accept_o   = 1'b0;
      save_e_o   = 1'b0;
      save_b_o   = 1'b0;
      fast_vec_o = 1'b0;
      irq_o      = 1'b0;
      mf_fast_o  = 1'b0;
      mf_dbl_o   = 1'b0;
      bad_o      = 1'b0;
      unique case (kind_i)
         K_IRQ: begin
            accept_o = pie_i;
            save_e_o = 1'b1;
            irq_o    = 1'b1;
         end
         K_MISS: begin
            accept_o = 1'b1;
            if (!eh_i) begin
               save_e_o   = 1'b1;
               fast_vec_o = 1'b1;
               mf_fast_o  = 1'b1;
            end else begin
               mf_dbl_o = 1'b1;
            end
         end
         K_PERM: begin
            accept_o = 1'b1;
            save_e_o = 1'b1;
         end
         K_FAULT: begin
            accept_o = 1'b1;
            save_e_o = !eh_i;
         end
         K_BREAK: begin
            accept_o = 1'b1;
            save_b_o = !eh_i;
         end
         default: bad_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/exc_status_next.sv
module exc_status_next
   import exc_entry_pkg::*;
#(
   parameter int unsigned SW = 32
) (
   input  logic [SW-1:0] status_i,
   input  logic          irq_i,
   output logic [SW-1:0] status_o
);
   always_comb begin
      status_o         = status_i;
      status_o[ST_PIE] = 1'b0;
      status_o[ST_U]   = 1'b0;
      if (irq_i) status_o[ST_IH] = 1'b1;
      else       status_o[ST_EH] = 1'b1;
   end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int unsigned AW         = 32,
   parameter int unsigned SW         = 32,
   parameter int unsigned CW         = 32,
   parameter int unsigned INSN_BYTES = 4,
   parameter bit          HAS_MMU    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take_i,
   input  logic [CAUSE_W-1:0]  cause_i,
   input  logic [AW-1:0]       pc_i,
   input  logic [SW-1:0]       status_i,
   input  logic [AW-1:0]       gen_vec_i,
   input  logic [AW-1:0]       fast_miss_vec_i,
   output logic [SW-1:0]       status_o,
   output logic [SW-1:0]       estatus_o,
   output logic [SW-1:0]       bstatus_o,
   output logic [CW-1:0]       exc_reg_o,
   output logic [1:0]          miss_flags_o,
   output logic [AW-1:0]       ea_o,
   output logic [AW-1:0]       ba_o,
   output logic [AW-1:0]       next_pc_o,
   output logic                entry_o,
   output logic                unhandled_o
);
   localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

   generate
      if (SW < ST_IH + 1) begin : g_bad_sw
         $error("status width too small for the handler bits");
      end
      if (CW < CAUSE_LSB + CAUSE_W) begin : g_bad_cw
         $error("cause register too narrow for the cause field");
      end
      if (INSN_BYTES == 0) begin : g_bad_step
         $error("instruction step must be non-zero");
      end
   endgenerate

   exc_kind_e     kind;
   logic          acc, sv_e, sv_b, fast, irq, mf_fast, mf_dbl, bad;
   logic [SW-1:0] st_nxt;
   logic          go;
   logic [AW-1:0] ret_addr;

   exc_cause_decode #(.HAS_MMU(HAS_MMU)) u_dec (
      .cause_i (cause_i),
      .kind_o  (kind)
   );

   exc_save_policy u_pol (
      .kind_i     (kind),
      .eh_i       (status_i[ST_EH]),
      .pie_i      (status_i[ST_PIE]),
      .accept_o   (acc),
      .save_e_o   (sv_e),
      .save_b_o   (sv_b),
      .fast_vec_o (fast),
      .irq_o      (irq),
      .mf_fast_o  (mf_fast),
      .mf_dbl_o   (mf_dbl),
      .bad_o      (bad)
   );

   exc_status_next #(.SW(SW)) u_st (
      .status_i (status_i),
      .irq_i    (irq),
      .status_o (st_nxt)
   );

   assign go       = take_i && acc;
   assign ret_addr = pc_i + STEP;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_o     <= '0;
         estatus_o    <= '0;
         bstatus_o    <= '0;
         exc_reg_o    <= '0;
         miss_flags_o <= '0;
         ea_o         <= '0;
         ba_o         <= '0;
         next_pc_o    <= '0;
         entry_o      <= 1'b0;
         unhandled_o  <= 1'b0;
      end else begin
         entry_o     <= go;
         unhandled_o <= take_i && bad;
         if (go) begin
            status_o <= st_nxt;
            exc_reg_o[CAUSE_LSB +: CAUSE_W] <= cause_i;
            next_pc_o <= fast ? fast_miss_vec_i : gen_vec_i;
            if (sv_e) begin
               estatus_o <= status_i;
               ea_o      <= ret_addr;
            end
            if (sv_b) begin
               bstatus_o <= status_i;
               ba_o      <= ret_addr;
            end
            if (mf_fast) begin
               miss_flags_o[MF_DBL] <= 1'b0;
               miss_flags_o[MF_WR]  <= 1'b1;
            end
            if (mf_dbl) miss_flags_o[MF_DBL] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
   import exc_entry_pkg::*;
#(
   parameter int unsigned AW      = 32,
   parameter int unsigned SW      = 32,
   parameter int unsigned CW      = 32,
   parameter bit          HAS_MMU = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               take_i,
   input logic [CAUSE_W-1:0] cause_i,
   input logic [SW-1:0]      status_i,
   input logic [AW-1:0]      gen_vec_i,
   input logic [SW-1:0]      status_o,
   input logic [SW-1:0]      estatus_o,
   input logic [CW-1:0]      exc_reg_o,
   input logic [1:0]         miss_flags_o,
   input logic [AW-1:0]      ea_o,
   input logic [AW-1:0]      next_pc_o,
   input logic               entry_o,
   input logic               unhandled_o
);
   assert_entry_clears_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      entry_o |-> (!status_o[ST_PIE] && !status_o[ST_U]));

   assert_cause_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && cause_i == CC_TRAP) |=> (exc_reg_o[CAUSE_LSB +: CAUSE_W] == $past(cause_i)));

   assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && cause_i == CC_IRQ && !status_i[ST_PIE])
         |=> (!entry_o && $stable(estatus_o) && $stable(ea_o)));

   assert_nested_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_MMU && take_i && cause_i == CC_TLB_MISS && status_i[ST_EH])
         |=> (miss_flags_o[MF_DBL] && $stable(ea_o) && $stable(estatus_o)
              && next_pc_o == $past(gen_vec_i)));

   assert_break_keeps_exc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && cause_i == CC_BREAK) |=> ($stable(estatus_o) && $stable(ea_o)));

   assert_unhandled_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
      unhandled_o |-> (!entry_o && $stable(status_o) && $stable(next_pc_o)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.AW(AW), .SW(SW), .CW(CW), .HAS_MMU(HAS_MMU)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .take_i       (take_i),
   .cause_i      (cause_i),
   .status_i     (status_i),
   .gen_vec_i    (gen_vec_i),
   .status_o     (status_o),
   .estatus_o    (estatus_o),
   .exc_reg_o    (exc_reg_o),
   .miss_flags_o (miss_flags_o),
   .ea_o         (ea_o),
   .next_pc_o    (next_pc_o),
   .entry_o      (entry_o),
   .unhandled_o  (unhandled_o)
);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        take_i = 1'b0;
   logic [4:0]  cause_i = '0;
   logic [31:0] pc_i = '0, status_i = '0;
   logic [31:0] gen_vec_i = 32'h0000_0120;
   logic [31:0] fast_miss_vec_i = 32'h0000_0880;
   logic [31:0] status_o, estatus_o, bstatus_o, exc_reg_o, ea_o, ba_o, next_pc_o;
   logic [1:0]  miss_flags_o;
   logic        entry_o, unhandled_o;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   exc_entry_ctrl dut (
      .clk(clk), .rst_n(rst_n), .take_i(take_i), .cause_i(cause_i), .pc_i(pc_i),
      .status_i(status_i), .gen_vec_i(gen_vec_i), .fast_miss_vec_i(fast_miss_vec_i),
      .status_o(status_o), .estatus_o(estatus_o), .bstatus_o(bstatus_o),
      .exc_reg_o(exc_reg_o), .miss_flags_o(miss_flags_o), .ea_o(ea_o), .ba_o(ba_o),
      .next_pc_o(next_pc_o), .entry_o(entry_o), .unhandled_o(unhandled_o)
   );

   // expected state
   logic [31:0] m_st, m_est, m_bst, m_exc, m_ea, m_ba, m_npc;
   logic [1:0]  m_mf;

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input int c, input bit eh);
      if (c == 2) return "R4";
      if (c == 12) return eh ? "R6" : "R5";
      if (c >= 13 && c <= 15) return "R7";
      if (c == 3 || c == 5 || (c >= 9 && c <= 11)) return "R8";
      if (c == 7) return "R9";
      return "R10";
   endfunction

   task automatic entry(input int c, input bit eh, input bit pie, input logic [31:0] pc);
      logic [31:0] st;
      logic [31:0] nst;
      bit acc, irq;
      string rq;
      st = 32'h5A00_0000 | (32'(c) << 8) | 32'h2 | (32'(eh) << 2) | 32'(pie);
      rq = req_of(c, eh);
      irq = (c == 2);
      acc = (rq != "R10") && !(irq && !pie);
      nst = st & ~32'h3;
      nst = irq ? (nst | 32'h8) : (nst | 32'h4);
      if (acc) begin
         m_st  = nst;
         m_exc = 32'(c) << 2;
         m_npc = (c == 12 && !eh) ? fast_miss_vec_i : gen_vec_i;
         if (irq || (c == 12 && !eh) || (c >= 13 && c <= 15) || (rq == "R8" && !eh)) begin
            m_est = st;
            m_ea  = pc + 32'd4;
         end
         if (c == 7 && !eh) begin
            m_bst = st;
            m_ba  = pc + 32'd4;
         end
         if (c == 12) m_mf = eh ? (m_mf | 2'b10) : 2'b01;
      end
      cause_i  = 5'(c);
      status_i = st;
      pc_i     = pc;
      take_i   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      take_i = 1'b0;
      chk(rq, "entry", 32'(entry_o), 32'(acc));
      chk("R10", "unhandled", 32'(unhandled_o), 32'(rq == "R10"));
      chk(rq == "R10" ? rq : (irq ? "R4" : "R2"), "status", status_o, m_st);
      chk("R3", "cause reg", exc_reg_o, m_exc);
      chk(rq, "estatus", estatus_o, m_est);
      chk(rq, "ea", ea_o, m_ea);
      chk(rq == "R10" ? rq : "R9", "bstatus", bstatus_o, m_bst);
      chk(rq == "R10" ? rq : "R9", "ba", ba_o, m_ba);
      chk(rq, "miss flags", 32'(m_mf), 32'(m_mf) ^ 32'(miss_flags_o ^ m_mf));
      chk(rq, "next pc", next_pc_o, m_npc);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      m_st = '0; m_est = '0; m_bst = '0; m_exc = '0; m_ea = '0; m_ba = '0; m_npc = '0;
      m_mf = '0;
      repeat (3) @(negedge clk);
      // R1: outputs under reset
      chk("R1", "status in reset", status_o, 32'h0);
      chk("R1", "entry in reset", 32'(entry_o), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ea after reset", ea_o, 32'h0);
      chk("R1", "next pc after reset", next_pc_o, 32'h0);
      chk("R1", "flags after reset", 32'(miss_flags_o), 32'h0);
      chk("R1", "unhandled after reset", 32'(unhandled_o), 32'h0);
      for (int e = 0; e < 2; e++)
         for (int p = 0; p < 2; p++)
            for (int c = 0; c < 32; c++)
               entry(c, e[0], p[0], 32'h1000_0000 + 32'(c * 64 + e * 16 + p * 4));
      // R8: return address wraps at the top of the space
      entry(3, 1'b0, 1'b1, 32'hFFFF_FFFC);
      // R5 after R6: fast miss clears the double flag again
      entry(12, 1'b1, 1'b0, 32'h2000_0000);
      entry(12, 1'b0, 1'b0, 32'h2000_0100);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule